// File: doc/BRIEF.md
# Masked-Comparator Sequential Trigger

This block watches a 32-bit sampled bus and raises a trigger when a programmed pattern of events has been seen. Four comparators each check the full bus against their own compare word and care mask, so each produces one event bit for every sample. A sequencer then walks through up to four stages. Each stage names a set of events, and any one event from that set advances the stage. Listing the stages one after another gives ordered sequences, and putting more than one event in a stage gives alternatives. The two can be nested, so a program such as "(E0 or E1) then (E2 or E3)" is a two-stage program.

Software programs the comparators and the stage program through a write-only register port, then arms the unit by writing the arm address. While the unit is armed, every configuration write is dropped. When the last stage is satisfied, the unit emits a one-cycle trigger pulse and returns to idle. It stays idle until it is armed again.

Register addresses: compare word of comparator k at address k (0..3), care mask of comparator k at address 4+k, stage program at address 8, arm at address 9. In the stage program word, the select for stage i sits in bits [4i+3:4i], where bit k selects event Ek. Bits [17:16] hold the index of the last stage, which is the stage count minus one.

Top module: `trig_seq_unit`

## Requirements
- R1: Event Ek is true for a sample exactly when ((sample ^ compare_k) & mask_k) == 0. A mask of zero always matches.
- R2: After reset, armed_o and trig_o are 0, and all compare words, masks and stage selects are 0.
- R3: A write to address 9 while idle sets armed_o in the following cycle and starts at stage 0.
- R4: While armed, a valid sample advances the current stage when any event whose bit is set in that stage's 4-bit select is true (alternation). A cycle with sample_vld_i low never advances.
- R5: A valid sample that satisfies none of the current stage's selected events leaves the stage where it is. It does not restart the sequence.
- R6: Bits [17:16] of the stage program give the last stage index (0..3). The trigger fires only when that stage is satisfied, after all earlier stages were satisfied in order.
- R7: trig_o is high for exactly one cycle, in the cycle after the edge that takes the satisfying sample. armed_o is low in that same cycle.
- R8: Configuration writes, including writes to the arm address, are ignored while armed_o is high. This includes the cycle in which the final stage fires.
- R9: A single sample advances at most one stage, even when it satisfies the next stage's select too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 32 | Sampled bus |
| sample_vld_i | input | 1 | sample_i holds a new sample |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_data_i | input | 32 | Register write data |
| trig_o | output | 1 | One-cycle trigger pulse |
| armed_o | output | 1 | Unit is armed and waiting |

## Verification
A register write and the sample that satisfies the final stage can land in the same cycle. The bench provokes this by writing the arm address, and separately a compare word, in the very cycle that carries the final qualifying sample. The unit is still armed in that cycle, so both writes must be dropped: trig_o must pulse, armed_o must fall and stay low, and a later program run must behave as if the old compare word were still in place. The comparator function and the stage walk are swept across masks, select sets and stage counts. A bench-side model, derived from the requirements, predicts each trigger.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned N_CMP = 4;
  localparam int unsigned N_STG = 4;
endpackage

// File: rtl/trig_cmp.sv
module trig_cmp #(
  parameter int unsigned BUS_W = trig_pkg::BUS_W
) (
  input  logic [BUS_W-1:0] sample_i,
  input  logic [BUS_W-1:0] value_i,
  input  logic [BUS_W-1:0] mask_i,
  output logic             hit_o
);
  // cared bits must agree
  assign hit_o = ~|((sample_i ^ value_i) & mask_i);
endmodule

// File: rtl/trig_cfg.sv
module trig_cfg #(
  parameter int unsigned BUS_W  = trig_pkg::BUS_W,
  parameter int unsigned N_CMP  = trig_pkg::N_CMP,
  parameter int unsigned N_STG  = trig_pkg::N_STG,
  parameter int unsigned ADDR_W = $clog2(2*N_CMP+2),
  parameter int unsigned STG_W  = $clog2(N_STG)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [BUS_W-1:0]                  data_i,
  input  logic                              armed_i,
  output logic [N_CMP-1:0][BUS_W-1:0]       val_o,
  output logic [N_CMP-1:0][BUS_W-1:0]       msk_o,
  output logic [N_STG-1:0][N_CMP-1:0]       sel_o,
  output logic [STG_W-1:0]                  last_o,
  output logic                              arm_o
);
  localparam int unsigned PROG_A = 2*N_CMP;
  localparam int unsigned ARM_A  = 2*N_CMP+1;
  localparam int unsigned PROG_W = N_STG*N_CMP + STG_W;

  logic [N_CMP-1:0][BUS_W-1:0] val_q, msk_q;
  logic [PROG_W-1:0]           prog_q;
  logic                        wr_ok;

  assign wr_ok = we_i && !armed_i;
  assign arm_o = wr_ok && (addr_i == ADDR_W'(ARM_A));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      msk_q  <= '0;
      prog_q <= '0;
    end else if (wr_ok) begin
      for (int k = 0; k < int'(N_CMP); k++) begin
        if (addr_i == ADDR_W'(k))         val_q[k] <= data_i;
        if (addr_i == ADDR_W'(N_CMP + k)) msk_q[k] <= data_i;
      end
      if (addr_i == ADDR_W'(PROG_A)) prog_q <= data_i[PROG_W-1:0];
    end
  end

  assign val_o = val_q;
  assign msk_o = msk_q;

  generate
    for (genvar i = 0; i < N_STG; i++) begin : g_sel
      assign sel_o[i] = prog_q[i*N_CMP +: N_CMP];
    end
  endgenerate
  assign last_o = prog_q[N_STG*N_CMP +: STG_W];

  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> ($stable(val_q) && $stable(msk_q) && $stable(prog_q)));
endmodule

// File: rtl/trig_seqr.sv
module trig_seqr #(
  parameter int unsigned N_CMP = trig_pkg::N_CMP,
  parameter int unsigned N_STG = trig_pkg::N_STG,
  parameter int unsigned STG_W = $clog2(N_STG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        arm_i,
  input  logic                        vld_i,
  input  logic [N_CMP-1:0]            evt_i,
  input  logic [N_STG-1:0][N_CMP-1:0] sel_i,
  input  logic [STG_W-1:0]            last_i,
  output logic                        armed_o,
  output logic                        trig_o
);
  logic             armed_q, trig_q;
  logic [STG_W-1:0] stg_q;
  logic             hit;

  assign hit = |(evt_i & sel_i[stg_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      stg_q   <= '0;
    end else begin
      trig_q <= 1'b0;
      if (arm_i) begin
        armed_q <= 1'b1;
        stg_q   <= '0;
      end else if (armed_q && vld_i && hit) begin
        if (stg_q == last_i) begin
          armed_q <= 1'b0;
          trig_q  <= 1'b1;
          stg_q   <= '0;
        end else begin
          stg_q <= stg_q + STG_W'(1);
        end
      end
    end
  end

  assign armed_o = armed_q;
  assign trig_o  = trig_q;

  // R7
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);
  // R7
  trig_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> !armed_q);
  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !trig_q);
  // R4
  no_vld_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !vld_i) |=> $stable(stg_q));
  // R5
  no_evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && vld_i && (evt_i == '0)) |=> ($stable(stg_q) && armed_q));
  // R6
  stage_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (stg_q <= last_i));
  // R9
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> (!armed_q || stg_q == $past(stg_q) || stg_q == $past(stg_q) + STG_W'(1)));
endmodule

// File: rtl/trig_seq_unit.sv
module trig_seq_unit #(
  parameter int unsigned BUS_W  = trig_pkg::BUS_W,
  parameter int unsigned N_CMP  = trig_pkg::N_CMP,
  parameter int unsigned N_STG  = trig_pkg::N_STG,
  parameter int unsigned ADDR_W = $clog2(2*N_CMP+2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  sample_i,
  input  logic              sample_vld_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [BUS_W-1:0]  cfg_data_i,
  output logic              trig_o,
  output logic              armed_o
);
  localparam int unsigned STG_W = $clog2(N_STG);

  logic [N_CMP-1:0][BUS_W-1:0] val, msk;
  logic [N_STG-1:0][N_CMP-1:0] sel;
  logic [STG_W-1:0]            last;
  logic [N_CMP-1:0]            evt;
  logic                        arm, armed;

  trig_cfg #(.BUS_W(BUS_W), .N_CMP(N_CMP), .N_STG(N_STG), .ADDR_W(ADDR_W), .STG_W(STG_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .data_i(cfg_data_i), .armed_i(armed), .val_o(val), .msk_o(msk),
    .sel_o(sel), .last_o(last), .arm_o(arm)
  );

  generate
    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
      trig_cmp #(.BUS_W(BUS_W)) u_cmp (
        .sample_i(sample_i), .value_i(val[k]), .mask_i(msk[k]), .hit_o(evt[k])
      );
    end
  endgenerate

  trig_seqr #(.N_CMP(N_CMP), .N_STG(N_STG), .STG_W(STG_W)) u_seqr (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .vld_i(sample_vld_i),
    .evt_i(evt), .sel_i(sel), .last_i(last), .armed_o(armed), .trig_o(trig_o)
  );

  assign armed_o = armed;

  // R3
  arm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == ADDR_W'(2*N_CMP+1) && !armed_o) |=> armed_o);
endmodule

// File: tb/sim_trig_seq_unit.sv
`timescale 1ns/1ps
module sim_trig_seq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sample = '0;
  logic        vld = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] data = '0;
  logic        trig, armed;

  int checks = 0;
  int fails  = 0;

  // bench-side model state
  logic [31:0] m_val [4];
  logic [31:0] m_msk [4];
  logic [3:0]  m_sel [4];
  int          m_last = 0;
  logic        m_armed = 1'b0;
  int          m_stg = 0;
  logic        e_trig = 1'b0;

  always #4 clk = ~clk;

  trig_seq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(vld),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_data_i(data),
    .trig_o(trig), .armed_o(armed)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] m_evt(input logic [31:0] s);
    logic [3:0] e;
    for (int k = 0; k < 4; k++) e[k] = (((s ^ m_val[k]) & m_msk[k]) == 32'h0);
    return e;
  endfunction

  function automatic void m_step(input logic [31:0] s);
    e_trig = 1'b0;
    if (m_armed && ((m_evt(s) & m_sel[m_stg]) != 4'h0)) begin
      if (m_stg == m_last) begin
        e_trig = 1'b1; m_armed = 1'b0; m_stg = 0;
      end else m_stg++;
    end
  endfunction

  function automatic void m_wr(input logic [3:0] a, input logic [31:0] d, input logic was_armed);
    if (was_armed) return;
    if (a < 4) m_val[a] = d;
    else if (a < 8) m_msk[a-4] = d;
    else if (a == 8) begin
      for (int i = 0; i < 4; i++) m_sel[i] = d[4*i +: 4];
      m_last = int'(d[17:16]);
    end else if (a == 9) begin
      m_armed = 1'b1; m_stg = 0;
    end
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    we = 1'b1; addr = a; data = d; vld = 1'b0;
    m_wr(a, d, m_armed);
    @(posedge clk); #1;
    we = 1'b0;
    chk(tag, armed, m_armed);
    chk(tag, trig, 1'b0);
  endtask

  task automatic smp(input logic [31:0] s, input string tag);
    @(negedge clk);
    sample = s; vld = 1'b1;
    m_step(s);
    @(posedge clk); #1;
    vld = 1'b0;
    chk(tag, trig, e_trig);
    chk(tag, armed, m_armed);
  endtask

  task automatic smp_wr(input logic [31:0] s, input logic [3:0] a, input logic [31:0] d, input string tag);
    logic pre;
    @(negedge clk);
    sample = s; vld = 1'b1; we = 1'b1; addr = a; data = d;
    pre = m_armed;
    m_step(s);
    m_wr(a, d, pre);
    @(posedge clk); #1;
    vld = 1'b0; we = 1'b0;
    chk(tag, trig, e_trig);
    chk(tag, armed, m_armed);
  endtask

  task automatic idle_cyc(input logic [31:0] s, input string tag);
    @(negedge clk);
    sample = s; vld = 1'b0;
    @(posedge clk); #1;
    chk(tag, trig, 1'b0);
    chk(tag, armed, m_armed);
  endtask

  function automatic logic [31:0] prog(input logic [3:0] s0, s1, s2, s3, input int last);
    return {14'h0, 2'(last), s3, s2, s1, s0};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, m, s;
    for (int k = 0; k < 4; k++) begin m_val[k] = '0; m_msk[k] = '0; m_sel[k] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state
    chk("R2 armed after reset", armed, 1'b0);
    chk("R2 trig after reset", trig, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    // R2: all-zero selects never advance, so an armed unit must stay armed
    wr(4'd9, 32'h0, "R3 arm from reset");
    smp(32'h0, "R2 zero selects hold");
    smp(32'hFFFF_FFFF, "R2 zero selects hold");
    // clear the armed state via a one-stage catch-all program is impossible while armed; reset instead
    @(negedge clk); rst_n = 1'b0; m_armed = 1'b0; m_stg = 0;
    @(negedge clk); rst_n = 1'b1;

    // R1 comparator sweep, one comparator per single-stage program
    for (int k = 0; k < 4; k++) begin
      v = 32'hA5C3_0F96 ^ (32'h1357_9BDF * k);
      m = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0000_FFFF : (k == 2) ? 32'hF0F0_F0F0 : 32'h0;
      wr(4'(k), v, "R1 cfg value");
      wr(4'(4 + k), m, "R1 cfg mask");
      wr(4'd8, prog(4'(1 << k), 4'h0, 4'h0, 4'h0, 0), "R1 cfg prog");
      wr(4'd9, 32'h0, "R3 arm");
      for (int j = 0; j < 34; j++) begin
        s = (j == 0) ? v : (j == 33) ? ~v : v ^ (32'h1 << (j - 1));
        smp(s, "R1 masked compare");
        if (!m_armed) wr(4'd9, 32'h0, "R3 rearm");
      end
      // park: feed a matching sample so the unit goes idle for the next config
      smp(v, "R1 exact match fires");
    end

    // comparators: Ek matches sample k+1 exactly
    for (int k = 0; k < 4; k++) begin
      wr(4'(k), 32'(k + 1), "R1 cfg value");
      wr(4'(4 + k), 32'hFFFF_FFFF, "R1 cfg mask");
    end

    // R6 stage counts 1..4 with ordered stages, gaps and out-of-order samples
    for (int n = 1; n <= 4; n++) begin
      wr(4'd8, prog(4'h1, 4'h2, 4'h4, 4'h8, n - 1), "R6 cfg prog");
      wr(4'd9, 32'h0, "R3 arm");
      for (int i = 0; i < n; i++) begin
        smp(32'd0, "R5 no event holds");
        smp(32'(((i + 1) % 4) + 1), "R5 wrong event holds");
        idle_cyc(32'(i + 1), "R4 no valid no advance");
        smp(32'(i + 1), "R6 ordered stage");
      end
    end

    // R4 alternation: (E0|E1) then (E2|E3), all sample pairs
    wr(4'd8, prog(4'h3, 4'hC, 4'h0, 4'h0, 1), "R4 cfg prog");
    for (int a = 0; a <= 4; a++) begin
      for (int b = 0; b <= 4; b++) begin
        if (!m_armed) wr(4'd9, 32'h0, "R3 arm");
        smp(32'(a), "R4 alternation first");
        smp(32'(b), "R4 alternation second");
      end
    end
    while (m_armed) begin
      smp(32'd1, "R4 drain");
      smp(32'd3, "R4 drain");
    end

    // R9 same event selected in every stage: one stage per sample
    wr(4'd8, prog(4'h1, 4'h1, 4'h1, 4'h1, 3), "R9 cfg prog");
    wr(4'd9, 32'h0, "R3 arm");
    for (int i = 0; i < 4; i++) smp(32'd1, "R9 one stage per sample");

    // R8 writes while armed are dropped
    wr(4'd8, prog(4'h2, 4'h0, 4'h0, 4'h0, 0), "R8 cfg prog");
    wr(4'd9, 32'h0, "R3 arm");
    wr(4'd1, 32'd99, "R8 value write while armed");
    wr(4'd8, prog(4'h1, 4'h0, 4'h0, 4'h0, 0), "R8 prog write while armed");
    wr(4'd9, 32'h0, "R8 arm write while armed");
    smp(32'd1, "R8 old prog kept");
    smp(32'd99, "R8 old value kept");
    // final stage fires in the same cycle as an arm write and a value write
    smp_wr(32'd2, 4'd9, 32'h0, "R8 arm write on firing cycle");
    idle_cyc(32'd0, "R7 pulse is one cycle");
    wr(4'd9, 32'h0, "R3 arm");
    smp_wr(32'd2, 4'd1, 32'd77, "R8 value write on firing cycle");
    chk("R7 disarmed on fire", armed, 1'b0);
    wr(4'd9, 32'h0, "R3 arm");
    smp(32'd77, "R8 value unchanged");
    smp(32'd2, "R8 value unchanged");
    idle_cyc(32'd2, "R7 idle after trigger");

    summary();
    $finish;
  end
endmodule